// File: doc/BRIEF.md
# Board Control Register File

This block is a byte-wide register file that sits behind a simple synchronous register bus inside a board-support FPGA. Software uses it to drive the shutdown and rate pins of a serial line transceiver, to read the positions of a rotary mode selector and a DIP switch, to set the brightness of a display backlight, to light a small group of discrete LEDs, and to show hexadecimal digits on a row of seven-segment displays.

Each access moves one byte. A write takes effect at the clock edge where `wr_en` is sampled. A read is registered: `rdata` is loaded at the edge where `rd_en` is sampled and keeps that value until the next read. The switch inputs pass through a two-stage synchronizer before a read can see them. The backlight is a pulse-width modulator driven by a free-running 8-bit counter and gated by an enable bit. Each digit register is decoded into segment lines. Each digit also has its own decimal-point bit.

Top module: `brd_ctl_regs`

## Requirements
- R1: After reset, the control register is 0x00, the backlight level is 0x80, every digit value and dot is 0, and the LED register is 0. The outputs are therefore: `line_rate_hi_o`=0, `line_shdn_o`=0, `bl_pwm_o`=0, `led_o`=0, every digit segment group = 0x3F, and `dot_o`=0.
- R2: The control register is at offset 0x00. Bit 0 drives `line_rate_hi_o` (1 = high rate, 0 = low rate), bit 1 drives `line_shdn_o` (1 = driver shut down), and bit 2 is the backlight enable. Bits 7:3 read as zero. The outputs follow in the cycle after the write edge.
- R3: Offset 0x02 reads the mode switch in bits 2:0 and offset 0x03 reads the DIP switch in bits 3:0. Both are read-only: writes to them change nothing. Their upper bits read as zero. A change at the switch pins is visible to a read issued three or more cycles later.
- R4: The backlight level register is at offset 0x04 and can be read and written. While the enable bit is on, `bl_pwm_o` is high for exactly `level` cycles out of any 256 consecutive cycles. So 0x00 is never high and 0xFF is high for 255 of every 256 cycles.
- R5: While the backlight enable bit is 0, `bl_pwm_o` stays low, whatever the level.
- R6: Digit i (i = 0..15) is at offset 0x10+i. Bits 3:0 hold the value and bit 4 holds the dot, where 1 means lit. Bits 7:5 read as zero. `seg_o[7*i+6 : 7*i]` carries segments g..a with segment a in bit 0, and is active-high. The glyph codes for values 0..F are: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. `dot_o[i]` carries the dot.
- R7: The LED register is at offset 0x20. Bits 3:0 drive `led_o` (1 = on) and read back. Bits 7:4 read as zero. `led_o` changes only on a write to 0x20.
- R8: Reads of unmapped offsets (0x01, 0x05..0x0F, 0x11+.. beyond the digits, 0x21..0xFF) return 0x00. Writes to those offsets leave every register and output unchanged.
- R9: `rdata` changes only at an edge where `rd_en` is sampled. When a read and a write to the same offset fall in the same cycle, the read returns the value held before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte |
| rd_en | input | 1 | Read strobe, one byte |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| mode_sw_i | input | 3 | Rotary mode switch pins (asynchronous) |
| dip_sw_i | input | 4 | DIP switch pins (asynchronous) |
| line_rate_hi_o | output | 1 | Serial driver rate select, 1 = high |
| line_shdn_o | output | 1 | Serial driver shutdown, 1 = shut down |
| bl_pwm_o | output | 1 | Backlight PWM |
| led_o | output | 4 | Discrete LEDs, active-high |
| seg_o | output | 112 | Segment lines, seven per digit, segment a in the low bit |
| dot_o | output | 16 | Decimal points, one per digit |

## Verification
Two functions can land in the same cycle: a register read and a register write to the same offset. The bench raises both strobes together on the LED register and on the backlight register. The scoreboard expects the read to return the old contents. A following read must then return the new contents, and the LED pins must show the new value. A second overlap is a backlight level write that arrives while the PWM is running. That case is judged by counting high cycles over a full 256-cycle window once the new level has settled.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MODE = 8'h02;
  localparam logic [ADDR_W-1:0] OFF_DIP  = 8'h03;
  localparam logic [ADDR_W-1:0] OFF_BL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DIG  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_LED  = 8'h20;

  localparam int CTL_RATE_BIT = 0;
  localparam int CTL_SHDN_BIT = 1;
  localparam int CTL_BLEN_BIT = 2;
  localparam int CTL_W        = 3;
  localparam int DIG_DOT_BIT  = 4;
  localparam logic [DATA_W-1:0] BL_RESET = 8'h80;

  // Seven-segment glyph for a hex nibble, segment a in bit 0.
  function automatic logic [6:0] hex_glyph(input logic [3:0] nib);
    logic [6:0] g;
    case (nib)
      4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
      4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
      4'h8: g = 7'h7F; 4'h9: g = 7'h6F; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
      4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
    endcase
    return g;
  endfunction

  // PWM comparison: high while count is below level, gated by enable.
  function automatic logic pwm_high(input logic [7:0] cnt, input logic [7:0] lvl,
                                    input logic en);
    return en && (cnt < lvl);
  endfunction
endpackage

// File: rtl/brd_sync.sv
module brd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/brd_bl_pwm.sv
module brd_bl_pwm
  import brd_ctl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] level_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      pwm_q <= pwm_high(cnt_q, level_i, en_i);
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/brd_seg_bank.sv
module brd_seg_bank
  import brd_ctl_pkg::*;
#(
  parameter int NUM_DIGITS = 16
) (
  input  logic [NUM_DIGITS*4-1:0] val_i,
  output logic [NUM_DIGITS*7-1:0] seg_o
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    assign seg_o[i*7 +: 7] = hex_glyph(val_i[i*4 +: 4]);
  end
endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
  import brd_ctl_pkg::*;
#(
  parameter int NUM_DIGITS = 16,
  parameter int NUM_LEDS   = 4,
  parameter int MODE_W     = 3,
  parameter int DIP_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [7:0]              addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  input  logic [MODE_W-1:0]       mode_sw_i,
  input  logic [DIP_W-1:0]        dip_sw_i,
  output logic                    line_rate_hi_o,
  output logic                    line_shdn_o,
  output logic                    bl_pwm_o,
  output logic [NUM_LEDS-1:0]     led_o,
  output logic [NUM_DIGITS*7-1:0] seg_o,
  output logic [NUM_DIGITS-1:0]   dot_o
);
  localparam int DIG_FLAT_W = NUM_DIGITS * 4;

  logic [CTL_W-1:0]      ctl_q;
  logic [DATA_W-1:0]     bl_level_q;
  logic [DIG_FLAT_W-1:0] dig_val_q;
  logic [NUM_DIGITS-1:0] dig_dot_q;
  logic [NUM_LEDS-1:0]   led_q;
  logic [DATA_W-1:0]     rdata_q;
  logic [DATA_W-1:0]     rd_next;
  logic [MODE_W-1:0]     mode_s;
  logic [DIP_W-1:0]      dip_s;

  // Named internal events for the checker.
  logic              bl_en_w;
  logic [DATA_W-1:0] bl_level_w;
  logic              wr_ctl_w, wr_bl_w, wr_led_w;

  assign wr_ctl_w   = wr_en && (addr == OFF_CTL);
  assign wr_bl_w    = wr_en && (addr == OFF_BL);
  assign wr_led_w   = wr_en && (addr == OFF_LED);
  assign bl_en_w    = ctl_q[CTL_BLEN_BIT];
  assign bl_level_w = bl_level_q;

  brd_sync #(.W(MODE_W), .STAGES(SYNC_STAGES)) u_sync_mode (
    .clk(clk), .rst_n(rst_n), .d_i(mode_sw_i), .q_o(mode_s));
  brd_sync #(.W(DIP_W), .STAGES(SYNC_STAGES)) u_sync_dip (
    .clk(clk), .rst_n(rst_n), .d_i(dip_sw_i), .q_o(dip_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      bl_level_q <= BL_RESET;
      led_q      <= '0;
    end else begin
      if (wr_ctl_w) ctl_q      <= wdata[CTL_W-1:0];
      if (wr_bl_w)  bl_level_q <= wdata;
      if (wr_led_w) led_q      <= wdata[NUM_LEDS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_val_q <= '0;
      dig_dot_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_DIGITS; i++) begin
        if (addr == OFF_DIG + 8'(i)) begin
          dig_val_q[i*4 +: 4] <= wdata[3:0];
          dig_dot_q[i]        <= wdata[DIG_DOT_BIT];
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == OFF_CTL)  rd_next = DATA_W'(ctl_q);
    if (addr == OFF_MODE) rd_next = DATA_W'(mode_s);
    if (addr == OFF_DIP)  rd_next = DATA_W'(dip_s);
    if (addr == OFF_BL)   rd_next = bl_level_q;
    if (addr == OFF_LED)  rd_next = DATA_W'(led_q);
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (addr == OFF_DIG + 8'(i))
        rd_next = DATA_W'({dig_dot_q[i], dig_val_q[i*4 +: 4]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_next;
  end

  brd_bl_pwm #(.CNT_W(DATA_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .en_i(bl_en_w), .level_i(bl_level_q), .pwm_o(bl_pwm_o));

  brd_seg_bank #(.NUM_DIGITS(NUM_DIGITS)) u_seg (
    .val_i(dig_val_q), .seg_o(seg_o));

  assign rdata          = rdata_q;
  assign line_rate_hi_o = ctl_q[CTL_RATE_BIT];
  assign line_shdn_o    = ctl_q[CTL_SHDN_BIT];
  assign led_o          = led_q;
  assign dot_o          = dig_dot_q;
endmodule

// File: rtl/brd_ctl_regs_chk.sv
module brd_ctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       bl_pwm_o,
  input logic       line_rate_hi_o,
  input logic       line_shdn_o,
  input logic [3:0] led_o,
  input logic       bl_en_w,
  input logic [7:0] bl_level_w
);
  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h00) |=> (line_rate_hi_o == $past(wdata[0]) &&
                                  line_shdn_o == $past(wdata[1])));

  assert_mode_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'h02) |=> (rdata[7:3] == 5'b0));

  assert_bl_level_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_level_w == 8'h00) |=> !bl_pwm_o);

  assert_bl_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bl_en_w |=> !bl_pwm_o);

  assert_led_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 8'h20) |=> $stable(led_o));

  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 8'h01 || addr == 8'h05 || addr == 8'hFF)) |=> (rdata == 8'h00));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind brd_ctl_regs brd_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .bl_pwm_o(bl_pwm_o),
  .line_rate_hi_o(line_rate_hi_o), .line_shdn_o(line_shdn_o), .led_o(led_o),
  .bl_en_w(bl_en_w), .bl_level_w(bl_level_w));

// File: tb/brd_ctl_regs_tb_top.sv
module brd_ctl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0, wdata = '0;
  logic [7:0]   rdata;
  logic [2:0]   mode_sw = '0;
  logic [3:0]   dip_sw = '0;
  logic         rate_hi, shdn, pwm;
  logic [3:0]   led;
  logic [ND*7-1:0] seg;
  logic [ND-1:0]   dot;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_fire = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brd_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mode_sw_i(mode_sw), .dip_sw_i(dip_sw),
    .line_rate_hi_o(rate_hi), .line_shdn_o(shdn), .bl_pwm_o(pwm),
    .led_o(led), .seg_o(seg), .dot_o(dot));

  function automatic logic [6:0] ref_glyph(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares registered read data against the scoreboard.
  always @(posedge clk) rd_fire <= rd_en;
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R9 actual=0x%0h expected=<no pending read>", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(128'(rdata), 128'(e), t);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); rd_en = 1; addr = a; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr_rd(input logic [7:0] a, input logic [7:0] d, input logic [7:0] old,
                       input string tag);
    @(negedge clk); wr_en = 1; rd_en = 1; addr = a; wdata = d;
    exp_q.push_back(old); tag_q.push_back(tag);
    @(negedge clk); wr_en = 0; rd_en = 0;
  endtask

  task automatic pwm_count(input int exp, input string tag);
    int hi = 0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
    check(128'(hi), 128'(exp), tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(128'({rate_hi, shdn, pwm, led}), 128'(0), "R1 ctl/pwm/led outputs");
    check(128'(dot), 128'(0), "R1 dots");
    for (int i = 0; i < ND; i++) check(128'(seg[i*7 +: 7]), 128'(7'h3F), "R1 segment reset glyph");
    rd(8'h04, 8'h80, "R1 backlight reset level");
    rd(8'h00, 8'h00, "R1 control reset");
    rd(8'h20, 8'h00, "R1 led reset");

    // R2 control bits
    wr(8'h00, 8'h01);
    check(128'({rate_hi, shdn}), 128'(2'b10), "R2 rate high only");
    wr(8'h00, 8'h02);
    check(128'({rate_hi, shdn}), 128'(2'b01), "R2 shutdown only");
    wr(8'h00, 8'hF8);
    rd(8'h00, 8'h00, "R2 upper bits read zero");
    wr(8'h00, 8'hFF);
    rd(8'h00, 8'h07, "R2 readback");

    // R3 switches through synchronizer, read-only
    mode_sw = 3'd5; dip_sw = 4'hA;
    repeat (3) @(negedge clk);
    rd(8'h02, 8'h05, "R3 mode switch");
    rd(8'h03, 8'h0A, "R3 dip switch");
    wr(8'h02, 8'hFF); wr(8'h03, 8'h00);
    rd(8'h02, 8'h05, "R3 mode write ignored");
    rd(8'h03, 8'h0A, "R3 dip write ignored");
    mode_sw = 3'd2; dip_sw = 4'h3;
    repeat (3) @(negedge clk);
    rd(8'h02, 8'h02, "R3 mode change");
    rd(8'h03, 8'h03, "R3 dip change");

    // R4 PWM duty (enable on: control = 0x04 keeps rate/shdn low)
    wr(8'h00, 8'h04);
    pwm_count(128, "R4 level 0x80");
    wr(8'h04, 8'h00); pwm_count(0, "R4 level 0x00");
    wr(8'h04, 8'h01); pwm_count(1, "R4 level 0x01");
    wr(8'h04, 8'hFF); pwm_count(255, "R4 level 0xFF");
    wr_rd(8'h04, 8'h37, 8'hFF, "R9 backlight read during write");
    pwm_count(55, "R4 level 0x37 written during run");
    rd(8'h04, 8'h37, "R4 level readback");
    // R5 gate off
    wr(8'h00, 8'h00);
    pwm_count(0, "R5 enable off");

    // R6 digits
    for (int i = 0; i < ND; i++) wr(8'h10 + 8'(i), 8'(((i ^ 5) & 15) | ((i & 1) << 4) | 8'hE0));
    for (int i = 0; i < ND; i++) begin
      check(128'(seg[i*7 +: 7]), 128'(ref_glyph(4'((i ^ 5) & 15))), "R6 segment glyph");
      check(128'(dot[i]), 128'(i & 1), "R6 dot");
    end
    rd(8'h10, 8'h05, "R6 digit0 readback");
    rd(8'h1F, 8'h1A, "R6 digit15 readback");

    // R7 LEDs
    wr(8'h20, 8'hFA);
    check(128'(led), 128'(4'hA), "R7 led pins");
    rd(8'h20, 8'h0A, "R7 led readback");

    // R8 unmapped
    wr(8'h00, 8'h03);
    wr(8'h01, 8'hFF); wr(8'h05, 8'h00); wr(8'h21, 8'h00); wr(8'hFF, 8'h00); wr(8'h0F, 8'hFF);
    rd(8'h01, 8'h00, "R8 read 0x01");
    rd(8'h05, 8'h00, "R8 read 0x05");
    rd(8'h21, 8'h00, "R8 read 0x21");
    rd(8'hFF, 8'h00, "R8 read 0xFF");
    check(128'({rate_hi, shdn, led}), 128'({2'b11, 4'hA}), "R8 outputs unchanged");
    rd(8'h04, 8'h37, "R8 level unchanged");
    rd(8'h10, 8'h05, "R8 digit unchanged");

    // R9 simultaneous read/write, and hold
    wr_rd(8'h20, 8'h05, 8'h0A, "R9 led read during write");
    check(128'(led), 128'(4'h5), "R9 led write took effect");
    rd(8'h20, 8'h05, "R9 led new value");
    repeat (5) @(negedge clk);
    check(128'(rdata), 128'(8'h05), "R9 rdata holds when idle");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R9 actual=%0d pending expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule